// File: doc/BRIEF.md
# Power-Fail Write-Protect Controller

This block guards a static memory array while its main supply collapses and comes back. It watches a debounced power-fail flag and a separate low-supply flag, both from external comparators. It also watches the memory's active-low chip-enable and write-enable strobes. From these it drives a write-protect signal, a force that puts every data output in high impedance, and a select that moves the array onto its backup cell. All of its logic runs on one free-running clock.

A write that is already running when the power-fail flag rises may finish. The block cuts it off after a bounded number of cycles. Once power is good again, protection stays on for a fixed recovery delay. From reset the block sits in an isolated state that never selects the backup cell. The first clean power-up leaves that state for good. Both durations are parameters counted in clock cycles. A three-bit status output shows the current state for test.

Top module: `pwrfail_guard`

## Requirements
- R1: Reset is synchronous and active-low. After reset the state code is 0 (isolated), with `wprot_o`=1, `hiz_o`=1 and `bat_sel_o`=0. While isolated, `lowsup_i` is ignored and `bat_sel_o` stays 0. The state codes are: 0 isolated, 1 normal, 2 pending, 3 protected, 4 backup, 5 recover.
- R2: The isolated state is left at the first clock edge that sees `pfail_i`=0 and `lowsup_i`=0, and the block moves to recover. The isolated state is never entered again except by reset.
- R3: In normal (code 1) all three controls are 0. If `pfail_i` is seen at an edge and no write is in flight, the next state is protected (code 3). A write is in flight when `ce_n_i`=0 and `we_n_i`=0 at that edge and also at the edge before it.
- R4: If `pfail_i` is seen in normal while a write is in flight, the next state is pending (code 2). In pending all three controls stay 0. At the first edge that sees either strobe high, the next state is protected.
- R5: A pending state whose write never ends lasts exactly `WPT_CYC` cycles, and then the block becomes protected.
- R6: A write whose strobes first go low at the same edge that sees `pfail_i` is not accepted, and the next state is protected.
- R7: In protected, backup and recover, `wprot_o`=1 and `hiz_o`=1. Strobe activity in these states has no effect on the state or the outputs.
- R8: In protected, `lowsup_i`=1 moves the block to backup (code 4) with `bat_sel_o`=1. In backup, `lowsup_i`=0 returns it to protected with `bat_sel_o`=0.
- R9: If `pfail_i` drops in pending or protected, the next state is recover. Recover lasts exactly `REC_CYC` cycles and is then followed by normal.
- R10: If `pfail_i` rises during recover, the next state is protected. The next recovery again lasts the full `REC_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pfail_i | input | 1 | Supply below the power-fail threshold (debounced) |
| lowsup_i | input | 1 | Supply below the backup cell level |
| ce_n_i | input | 1 | Memory chip enable, active low |
| we_n_i | input | 1 | Memory write enable, active low |
| wprot_o | output | 1 | Write protect for the array |
| hiz_o | output | 1 | Forces all data outputs to high impedance |
| bat_sel_o | output | 1 | 1 selects the backup cell, 0 the main supply |
| state_o | output | 3 | Current state code (see R1) |

## Verification
Every output is decoded from the state register, so each output is due one edge after the input change that causes it. The only exceptions are the timed exits. Pending ends `WPT_CYC` edges after the edge that entered it. Recover ends `REC_CYC` edges after its entry edge. The bench drives inputs on the falling edge and counts the exact number of rising edges each vector needs. It samples on the next falling edge. Timed exits are checked one edge before the expected change and again at that edge.

// File: rtl/pfg_pkg.sv
`timescale 1ns/1ps
// Package: shared state type of the power-fail guard.
// Assumes the codes are visible on the status output, so the values are fixed.
package pfg_pkg;

    typedef enum logic [2:0] {
        ST_ISO  = 3'd0,
        ST_NORM = 3'd1,
        ST_PEND = 3'd2,
        ST_PROT = 3'd3,
        ST_BACK = 3'd4,
        ST_REC  = 3'd5
    } pfg_state_e;

    // Width of a down counter that holds values 0 .. len-1
    function automatic int cnt_width(input int len);
        return (len > 1) ? $clog2(len) : 1;
    endfunction

endpackage

// File: rtl/pfg_timer.sv
`timescale 1ns/1ps
// Module: one-shot cycle timer.
// A load pulse starts a window of LEN cycles. done rises in the last cycle
// of the window, provided en is held high during the window.
// Assumes LEN >= 1 and that load and en come from the owning state machine.
module pfg_timer #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic en,
    output logic done
);
    import pfg_pkg::*;

    localparam int W = cnt_width(LEN);
    localparam logic [W-1:0] START = W'(LEN - 1);

    logic [W-1:0] cnt_q;

    // Count down from the window start to zero, then hold at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= START;
        end else if (en && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Window is over once the count reaches zero
    always_comb begin
        done = (cnt_q == '0);
    end

endmodule

// File: rtl/pfg_acc_track.sv
`timescale 1ns/1ps
// Module: write-access tracker.
// acc_live is high while both strobes are low. acc_held is high only for a
// write that was already low at the previous edge, which is what separates
// a write in flight from one that starts at the same edge.
// Assumes the strobes are synchronous to clk.
module pfg_acc_track (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    output logic acc_live,
    output logic acc_held
);
    logic live;
    logic live_q;

    // A write is present when chip enable and write enable are both low
    always_comb begin
        live = ~ce_n & ~we_n;
    end

    // Remember whether a write was present at the previous edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= 1'b0;
        end else begin
            live_q <= live;
        end
    end

    // Drive the outputs from the present and the remembered write
    always_comb begin
        acc_live = live;
        acc_held = live & live_q;
    end

endmodule

// File: rtl/pfg_fsm.sv
`timescale 1ns/1ps
// Module: power-fail state sequencer.
// Moves between isolated, normal, pending, protected, backup and recover.
// It raises a load pulse for a timer whenever it enters that timer's state.
// Assumes pfail and lowsup are already debounced and synchronous.
module pfg_fsm (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pfail,
    input  logic                lowsup,
    input  logic                acc_live,
    input  logic                acc_held,
    input  logic                wpt_done,
    input  logic                rec_done,
    output pfg_pkg::pfg_state_e state,
    output logic                wpt_load,
    output logic                rec_load
);
    import pfg_pkg::*;

    pfg_state_e st_q;
    pfg_state_e st_d;

    // Next-state selection
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_ISO:  if (!pfail && !lowsup) st_d = ST_REC;
            ST_NORM: if (pfail)             st_d = acc_held ? ST_PEND : ST_PROT;
            ST_PEND: begin
                if (!pfail)                     st_d = ST_REC;
                else if (!acc_live || wpt_done) st_d = ST_PROT;
            end
            ST_PROT: begin
                if (!pfail)      st_d = ST_REC;
                else if (lowsup) st_d = ST_BACK;
            end
            ST_BACK: if (!lowsup) st_d = ST_PROT;
            ST_REC: begin
                if (pfail)         st_d = ST_PROT;
                else if (rec_done) st_d = ST_NORM;
            end
            default: st_d = ST_ISO;
        endcase
    end

    // State register; reset leaves the block in the isolated state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_ISO;
        end else begin
            st_q <= st_d;
        end
    end

    // Load each timer on entry into its timed state
    always_comb begin
        wpt_load = (st_d == ST_PEND) && (st_q != ST_PEND);
        rec_load = (st_d == ST_REC)  && (st_q != ST_REC);
        state    = st_q;
    end

endmodule

// File: rtl/pfg_outdec.sv
`timescale 1ns/1ps
// Module: control decode.
// Turns the state into the protect, tristate and backup-select controls.
// Pure combinational logic, so every control is valid in the same cycle as
// its state.
module pfg_outdec (
    input  pfg_pkg::pfg_state_e state,
    output logic                wprot,
    output logic                hiz,
    output logic                bat_sel,
    output logic [2:0]          code
);
    import pfg_pkg::*;

    // Only normal and pending leave the array open
    always_comb begin
        wprot   = !((state == ST_NORM) || (state == ST_PEND));
        hiz     = wprot;
        bat_sel = (state == ST_BACK);
        code    = state;
    end

endmodule

// File: rtl/pwrfail_guard.sv
`timescale 1ns/1ps
// Module: power-fail write-protect controller (top).
// Watches the power-fail and low-supply flags and the memory strobes. It
// write-protects the array, tristates its outputs and selects the backup
// cell as the supply falls. It lets a write in flight finish within
// WPT_CYC cycles and holds protection for REC_CYC cycles after recovery.
// Assumes all inputs are synchronous to clk.
module pwrfail_guard #(
    parameter int WPT_CYC = 12500,
    parameter int REC_CYC = 10000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pfail_i,
    input  logic       lowsup_i,
    input  logic       ce_n_i,
    input  logic       we_n_i,
    output logic       wprot_o,
    output logic       hiz_o,
    output logic       bat_sel_o,
    output logic [2:0] state_o
);
    import pfg_pkg::*;

    localparam int NTMR = 2;
    localparam int TMR_WPT = 0;
    localparam int TMR_REC = 1;

    logic       acc_live;
    logic       acc_held;
    pfg_state_e state;
    logic       wpt_load;
    logic       rec_load;
    logic [NTMR-1:0] tmr_load;
    logic [NTMR-1:0] tmr_en;
    logic [NTMR-1:0] tmr_done;

    pfg_acc_track u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n_i),
        .we_n     (we_n_i),
        .acc_live (acc_live),
        .acc_held (acc_held)
    );

    pfg_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pfail    (pfail_i),
        .lowsup   (lowsup_i),
        .acc_live (acc_live),
        .acc_held (acc_held),
        .wpt_done (tmr_done[TMR_WPT]),
        .rec_done (tmr_done[TMR_REC]),
        .state    (state),
        .wpt_load (wpt_load),
        .rec_load (rec_load)
    );

    // Route load and run enables to the two timers
    always_comb begin
        tmr_load[TMR_WPT] = wpt_load;
        tmr_load[TMR_REC] = rec_load;
        tmr_en[TMR_WPT]   = (state == ST_PEND);
        tmr_en[TMR_REC]   = (state == ST_REC);
    end

    for (genvar g = 0; g < NTMR; g++) begin : g_tmr
        localparam int LEN = (g == TMR_WPT) ? WPT_CYC : REC_CYC;
        pfg_timer #(.LEN(LEN)) u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (tmr_load[g]),
            .en    (tmr_en[g]),
            .done  (tmr_done[g])
        );
    end

    pfg_outdec u_dec (
        .state   (state),
        .wprot   (wprot_o),
        .hiz     (hiz_o),
        .bat_sel (bat_sel_o),
        .code    (state_o)
    );

endmodule

// File: rtl/pfg_chk.sv
`timescale 1ns/1ps
// Module: property checker for pwrfail_guard, attached by bind below.
// It observes only the ports. It keeps its own counters for the two timed
// windows, so no long delay has to be unrolled.
module pfg_chk #(
    parameter int WPT_CYC = 12500,
    parameter int REC_CYC = 10000000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pfail_i,
    input logic       lowsup_i,
    input logic       ce_n_i,
    input logic       we_n_i,
    input logic       wprot_o,
    input logic       hiz_o,
    input logic       bat_sel_o,
    input logic [2:0] state_o
);
    import pfg_pkg::*;

    int pend_cnt;
    int rec_cnt;

    // Count the cycles spent in pending and in recover
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_cnt <= 0;
            rec_cnt  <= 0;
        end else begin
            pend_cnt <= (state_o == ST_PEND) ? pend_cnt + 1 : 0;
            rec_cnt  <= (state_o == ST_REC)  ? rec_cnt + 1  : 0;
        end
    end

    // R1
    iso_nobat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_ISO && lowsup_i) |=> !bat_sel_o);

    // R2
    no_reiso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != ST_ISO) |=> (state_o != ST_ISO));

    // R3
    idle_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_NORM && pfail_i && (ce_n_i || we_n_i)) |=> (state_o == ST_PROT && wprot_o));

    // R4
    pend_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_PEND && pfail_i && (ce_n_i || we_n_i)) |=> (state_o == ST_PROT));

    // R5
    pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_cnt <= WPT_CYC);

    // R8
    backup_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bat_sel_o |-> (wprot_o && hiz_o));

    // R9
    rec_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_NORM && $past(state_o) == ST_REC) |-> (rec_cnt == REC_CYC));

    // R10
    rec_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_REC && pfail_i) |=> (state_o == ST_PROT));

endmodule

bind pwrfail_guard pfg_chk #(.WPT_CYC(WPT_CYC), .REC_CYC(REC_CYC)) u_pfg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pfail_i   (pfail_i),
    .lowsup_i  (lowsup_i),
    .ce_n_i    (ce_n_i),
    .we_n_i    (we_n_i),
    .wprot_o   (wprot_o),
    .hiz_o     (hiz_o),
    .bat_sel_o (bat_sel_o),
    .state_o   (state_o)
);

// File: tb/test_pwrfail_guard.sv
`timescale 1ns/1ps
// Bench: walks a vector table, then runs directed tests for the strobes and for reset.
module test_pwrfail_guard;

    localparam int WPT = 6;
    localparam int REC = 10;
    localparam logic [2:0] S_ISO = 3'd0, S_NRM = 3'd1, S_PND = 3'd2,
                           S_PRT = 3'd3, S_BCK = 3'd4, S_REC = 3'd5;

    typedef struct packed {
        logic       pf;
        logic       lo;
        logic       ce;
        logic       we;
        logic [7:0] cyc;
        logic [2:0] st;
        logic       wp;
        logic       hz;
        logic       bs;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b1,1'b1,1'b1,1'b1,8'd3, S_ISO,1'b1,1'b1,1'b0,4'd1},  // R1 low supply ignored
        '{1'b0,1'b0,1'b1,1'b1,8'd1, S_REC,1'b1,1'b1,1'b0,4'd2},  // R2 first power-up
        '{1'b0,1'b0,1'b1,1'b1,8'd9, S_REC,1'b1,1'b1,1'b0,4'd9},  // R9 one edge short
        '{1'b0,1'b0,1'b1,1'b1,8'd1, S_NRM,1'b0,1'b0,1'b0,4'd9},  // R9 exit edge
        '{1'b0,1'b0,1'b0,1'b1,8'd2, S_NRM,1'b0,1'b0,1'b0,4'd3},  // R3 read
        '{1'b1,1'b0,1'b0,1'b1,8'd1, S_PRT,1'b1,1'b1,1'b0,4'd3},  // R3 fail during read
        '{1'b0,1'b0,1'b1,1'b1,8'd1, S_REC,1'b1,1'b1,1'b0,4'd9},
        '{1'b0,1'b0,1'b1,1'b1,8'd4, S_REC,1'b1,1'b1,1'b0,4'd10},
        '{1'b1,1'b0,1'b1,1'b1,8'd1, S_PRT,1'b1,1'b1,1'b0,4'd10}, // R10 fail in recover
        '{1'b0,1'b0,1'b1,1'b1,8'd10,S_REC,1'b1,1'b1,1'b0,4'd10}, // R10 full restart
        '{1'b0,1'b0,1'b1,1'b1,8'd1, S_NRM,1'b0,1'b0,1'b0,4'd10},
        '{1'b0,1'b0,1'b0,1'b0,8'd2, S_NRM,1'b0,1'b0,1'b0,4'd4},
        '{1'b1,1'b0,1'b0,1'b0,8'd1, S_PND,1'b0,1'b0,1'b0,4'd4},  // R4 write in flight
        '{1'b1,1'b0,1'b0,1'b0,8'd5, S_PND,1'b0,1'b0,1'b0,4'd5},  // R5 last pending cycle
        '{1'b1,1'b0,1'b0,1'b0,8'd1, S_PRT,1'b1,1'b1,1'b0,4'd5},  // R5 timeout
        '{1'b1,1'b1,1'b1,1'b1,8'd1, S_BCK,1'b1,1'b1,1'b1,4'd8},  // R8 to backup
        '{1'b1,1'b0,1'b1,1'b1,8'd1, S_PRT,1'b1,1'b1,1'b0,4'd8},  // R8 back to main
        '{1'b0,1'b0,1'b1,1'b1,8'd1, S_REC,1'b1,1'b1,1'b0,4'd9},
        '{1'b0,1'b0,1'b1,1'b1,8'd10,S_NRM,1'b0,1'b0,1'b0,4'd9},
        '{1'b0,1'b0,1'b0,1'b0,8'd2, S_NRM,1'b0,1'b0,1'b0,4'd4},
        '{1'b1,1'b0,1'b0,1'b0,8'd2, S_PND,1'b0,1'b0,1'b0,4'd4},
        '{1'b1,1'b0,1'b1,1'b1,8'd1, S_PRT,1'b1,1'b1,1'b0,4'd4},  // R4 write ends
        '{1'b0,1'b0,1'b1,1'b1,8'd11,S_NRM,1'b0,1'b0,1'b0,4'd9},
        '{1'b1,1'b0,1'b0,1'b0,8'd1, S_PRT,1'b1,1'b1,1'b0,4'd6},  // R6 new write rejected
        '{1'b0,1'b0,1'b1,1'b1,8'd11,S_NRM,1'b0,1'b0,1'b0,4'd9},
        '{1'b0,1'b0,1'b0,1'b0,8'd1, S_NRM,1'b0,1'b0,1'b0,4'd4},
        '{1'b1,1'b0,1'b0,1'b0,8'd1, S_PND,1'b0,1'b0,1'b0,4'd4},
        '{1'b0,1'b0,1'b0,1'b0,8'd1, S_REC,1'b1,1'b1,1'b0,4'd9},  // R9 pending aborted
        '{1'b0,1'b0,1'b1,1'b1,8'd10,S_NRM,1'b0,1'b0,1'b0,4'd9}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pfail_i = 1'b0, lowsup_i = 1'b0, ce_n_i = 1'b1, we_n_i = 1'b1;
    logic wprot_o, hiz_o, bat_sel_o;
    logic [2:0] state_o;
    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pwrfail_guard #(.WPT_CYC(WPT), .REC_CYC(REC)) i_pwrfail_guard (
        .clk(clk), .rst_n(rst_n), .pfail_i(pfail_i), .lowsup_i(lowsup_i),
        .ce_n_i(ce_n_i), .we_n_i(we_n_i), .wprot_o(wprot_o), .hiz_o(hiz_o),
        .bat_sel_o(bat_sel_o), .state_o(state_o)
    );

    task automatic check(input int req, input logic [2:0] st, input logic wp,
                         input logic hz, input logic bs);
        n_run++;
        if (state_o !== st || wprot_o !== wp || hiz_o !== hz || bat_sel_o !== bs) begin
            n_fail++;
            $display("FAIL R%0d: got st=%0d wp=%b hz=%b bs=%b, expected st=%0d wp=%b hz=%b bs=%b",
                     req, state_o, wprot_o, hiz_o, bat_sel_o, st, wp, hz, bs);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(1, S_ISO, 1'b1, 1'b1, 1'b0);  // R1 reset state
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            pfail_i  = VEC[i].pf;
            lowsup_i = VEC[i].lo;
            ce_n_i   = VEC[i].ce;
            we_n_i   = VEC[i].we;
            repeat (int'(VEC[i].cyc)) @(posedge clk);
            @(negedge clk);
            check(int'(VEC[i].req), VEC[i].st, VEC[i].wp, VEC[i].hz, VEC[i].bs);
        end
        // R7: strobes toggled while protected change nothing
        pfail_i = 1'b1; ce_n_i = 1'b1; we_n_i = 1'b1;
        @(posedge clk); @(negedge clk);
        for (int k = 0; k < 6; k++) begin
            ce_n_i = k[0];
            we_n_i = k[1];
            @(posedge clk); @(negedge clk);
            check(7, S_PRT, 1'b1, 1'b1, 1'b0);
        end
        // R1: reset in normal operation returns to isolated; low supply then ignored
        rst_n = 1'b0; ce_n_i = 1'b1; we_n_i = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(1, S_ISO, 1'b1, 1'b1, 1'b0);
        rst_n = 1'b1; pfail_i = 1'b1; lowsup_i = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(1, S_ISO, 1'b1, 1'b1, 1'b0);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got no end of run, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule